// File: doc/BRIEF.md
# Local Bus to DSP Host-Port Bridge

This block is the glue logic between the byte-wide local bus of a PCI target device and the byte-wide host port of a signal processor. The local side presents two active-low chip selects, two high address bits, a byte-enable that serves as address bit 0, a write/read level and separate read and write strobes. The bridge turns these into the host port's select, register-select, byte-select, direction and data-strobe inputs. It steers data bytes in both directions and forwards the processor's interrupt to the local side as an active-high level.

Chip select 0 opens a register window. In this window the two high address bits pick the control register, the address register or the fixed-address data port. Chip select 1 opens a streaming window, which always selects the auto-incrementing data port, so that consecutive bytes land in consecutive host words. The processor's ready output is sampled by one flip-flop on the local clock and returned as a one-cycle local ready pulse per byte. Accesses that fall outside both windows complete at once, so the local bus never waits on them.

Top module: `lbus_hp_bridge`

## Requirements
- R1: While reset is asserted, and at the first sample after reset, `lb_ready` is low.
- R2: `hp_cs_n` is low only when the access hits a window. The register window is `lb_cs_n[0]` low with `lb_addr_hi` not equal to 2'b01. The streaming window is `lb_cs_n[1]` low with `lb_cs_n[0]` high, so chip select 0 takes priority when both are low.
- R3: In the register window `hp_rsel` equals `lb_addr_hi` (2'b00 control, 2'b10 address, 2'b11 fixed data). Otherwise `hp_rsel` is 2'b01, the auto-incrementing data port, whatever the address bits.
- R4: `hp_byte_sel` follows `lb_be0`, and `hp_rnw` is the inverse of `lb_wnr` (local high = write, host high = read).
- R5: `hp_ds1_n` follows `lb_rd_n` and `hp_ds2_n` follows `lb_wr_n`.
- R6: `lb_int` is the inverse of the active-low `hp_int_n`.
- R7: `lb_dq_oe` is high only while a chip select is low and `lb_rd_n` is low. `lb_dq_out` carries `hp_dq_in` on a window hit and the value 8'hFF otherwise.
- R8: `hp_dq_oe` is high only while the access hits a window, `lb_wr_n` is low and `lb_wnr` is high. `hp_dq_out` carries `lb_dq_in`.
- R9: During a window hit, `lb_ready` stays low until `hp_rdy` is sampled high at a clock edge. It then rises at that same edge.
- R10: `lb_ready` is high for exactly one clock per access. It stays low while the strobe is held, and rearms only after both strobes go high.
- R11: An access that hits no window drives `lb_ready` high at the first clock edge of the access, whatever `hp_rdy` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Active-low reset |
| lb_cs_n | input | 2 | Local chip selects; bit 0 register window, bit 1 streaming window |
| lb_addr_hi | input | 2 | Local high address bits used as register code |
| lb_be0 | input | 1 | Byte-enable 0 (address bit 0), picks first or second byte |
| lb_wnr | input | 1 | Local direction, high = write |
| lb_rd_n | input | 1 | Local read strobe, active low |
| lb_wr_n | input | 1 | Local write strobe, active low |
| lb_dq_in | input | 8 | Byte from the local bus pad |
| lb_dq_out | output | 8 | Byte toward the local bus pad |
| lb_dq_oe | output | 1 | Output enable of the local data pad |
| lb_ready | output | 1 | Registered ready to the local bus, one pulse per byte |
| lb_int | output | 1 | Active-high interrupt to the local bus |
| hp_cs_n | output | 1 | Host-port select, active low |
| hp_rsel | output | 2 | Host-port register select |
| hp_byte_sel | output | 1 | Host-port first/second byte identify |
| hp_rnw | output | 1 | Host-port direction, high = host reads |
| hp_ds1_n | output | 1 | Host-port data strobe 1 |
| hp_ds2_n | output | 1 | Host-port data strobe 2 |
| hp_dq_in | input | 8 | Byte from the host-port pad |
| hp_dq_out | output | 8 | Byte toward the host-port pad |
| hp_dq_oe | output | 1 | Output enable of the host-port data pad |
| hp_rdy | input | 1 | Host-port ready, high = ready |
| hp_int_n | input | 1 | Host-port interrupt, active low |

## Verification
The assertions assume that the local master never lowers both strobes at once. They also assume that an access keeps its chip select and strobe stable until ready has been returned, and that strobes rise before a new byte begins. Under these conditions the two data-pad enables never overlap, and the ready flop sees one clean access per byte. The bench drives every access as a held strobe that is released only after the ready pulse, with at least one idle sample between bytes. It moves the processor ready line only while a strobe is held, so it stays inside these assumptions.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;

  typedef enum logic [1:0] {
    RS_CTRL     = 2'b00,
    RS_DATA_INC = 2'b01,
    RS_ADDR     = 2'b10,
    RS_DATA_FIX = 2'b11
  } rsel_e;

  typedef struct packed {
    logic  any_sel;
    logic  hit;
    rsel_e rsel;
  } win_t;

  // Window decode: chip select 0 is the register window and wins over
  // chip select 1; the register window does not carry the streaming code.
  function automatic win_t win_decode(input logic [1:0] cs_n,
                                      input logic [1:0] addr_hi);
    win_t w;
    w.any_sel = ~(cs_n[0] & cs_n[1]);
    if (!cs_n[0]) begin
      w.rsel = rsel_e'(addr_hi);
      w.hit  = (rsel_e'(addr_hi) != RS_DATA_INC);
    end else begin
      w.rsel = RS_DATA_INC;
      w.hit  = ~cs_n[1];
    end
    return w;
  endfunction

  // Ready go condition: missed windows never wait on the host port.
  function automatic logic ready_go(input logic hit, input logic hp_rdy);
    return hit ? hp_rdy : 1'b1;
  endfunction

endpackage

// File: rtl/bridge_decode.sv
`timescale 1ns/1ps
module bridge_decode
  import bridge_pkg::*;
(
  input  logic [1:0] lb_cs_n,
  input  logic [1:0] lb_addr_hi,
  input  logic       lb_be0,
  input  logic       lb_wnr,
  input  logic       lb_rd_n,
  input  logic       lb_wr_n,
  output logic       any_sel,
  output logic       hit,
  output logic       acc,
  output logic       hp_cs_n,
  output logic [1:0] hp_rsel,
  output logic       hp_byte_sel,
  output logic       hp_rnw,
  output logic       hp_ds1_n,
  output logic       hp_ds2_n
);
  win_t win;

  always_comb begin
    win         = win_decode(lb_cs_n, lb_addr_hi);
    any_sel     = win.any_sel;
    hit         = win.hit;
    acc         = win.any_sel & ~(lb_rd_n & lb_wr_n);
    hp_cs_n     = ~win.hit;
    hp_rsel     = win.rsel;
    hp_byte_sel = lb_be0;
    hp_rnw      = ~lb_wnr;
    hp_ds1_n    = lb_rd_n;
    hp_ds2_n    = lb_wr_n;
  end
endmodule

// File: rtl/bridge_datapath.sv
`timescale 1ns/1ps
module bridge_datapath #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] IDLE_BYTE = '1
) (
  input  logic              any_sel,
  input  logic              hit,
  input  logic              lb_wnr,
  input  logic              lb_rd_n,
  input  logic              lb_wr_n,
  input  logic [DATA_W-1:0] lb_dq_in,
  input  logic [DATA_W-1:0] hp_dq_in,
  output logic [DATA_W-1:0] lb_dq_out,
  output logic              lb_dq_oe,
  output logic [DATA_W-1:0] hp_dq_out,
  output logic              hp_dq_oe
);
  always_comb begin
    lb_dq_oe  = any_sel & ~lb_rd_n;
    lb_dq_out = hit ? hp_dq_in : IDLE_BYTE;
    hp_dq_oe  = hit & ~lb_wr_n & lb_wnr;
    hp_dq_out = lb_dq_in;
  end
endmodule

// File: rtl/bridge_ready.sv
`timescale 1ns/1ps
module bridge_ready
  import bridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic hit,
  input  logic hp_rdy,
  output logic ready,
  output logic done
);
  logic go;

  assign go = ready_go(hit, hp_rdy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      done  <= 1'b0;
    end else begin
      ready <= acc & ~done & ~ready & go;
      done  <= acc & (done | ready);
    end
  end
endmodule

// File: rtl/lbus_hp_bridge.sv
`timescale 1ns/1ps
module lbus_hp_bridge #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] IDLE_BYTE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lb_cs_n,
  input  logic [1:0]        lb_addr_hi,
  input  logic              lb_be0,
  input  logic              lb_wnr,
  input  logic              lb_rd_n,
  input  logic              lb_wr_n,
  input  logic [DATA_W-1:0] lb_dq_in,
  output logic [DATA_W-1:0] lb_dq_out,
  output logic              lb_dq_oe,
  output logic              lb_ready,
  output logic              lb_int,
  output logic              hp_cs_n,
  output logic [1:0]        hp_rsel,
  output logic              hp_byte_sel,
  output logic              hp_rnw,
  output logic              hp_ds1_n,
  output logic              hp_ds2_n,
  input  logic [DATA_W-1:0] hp_dq_in,
  output logic [DATA_W-1:0] hp_dq_out,
  output logic              hp_dq_oe,
  input  logic              hp_rdy,
  input  logic              hp_int_n
);
  logic any_sel_w;
  logic hit_w;
  logic acc_w;
  logic done_w;

  bridge_decode u_dec (
    .lb_cs_n     (lb_cs_n),
    .lb_addr_hi  (lb_addr_hi),
    .lb_be0      (lb_be0),
    .lb_wnr      (lb_wnr),
    .lb_rd_n     (lb_rd_n),
    .lb_wr_n     (lb_wr_n),
    .any_sel     (any_sel_w),
    .hit         (hit_w),
    .acc         (acc_w),
    .hp_cs_n     (hp_cs_n),
    .hp_rsel     (hp_rsel),
    .hp_byte_sel (hp_byte_sel),
    .hp_rnw      (hp_rnw),
    .hp_ds1_n    (hp_ds1_n),
    .hp_ds2_n    (hp_ds2_n)
  );

  bridge_datapath #(.DATA_W(DATA_W), .IDLE_BYTE(IDLE_BYTE)) u_dp (
    .any_sel   (any_sel_w),
    .hit       (hit_w),
    .lb_wnr    (lb_wnr),
    .lb_rd_n   (lb_rd_n),
    .lb_wr_n   (lb_wr_n),
    .lb_dq_in  (lb_dq_in),
    .hp_dq_in  (hp_dq_in),
    .lb_dq_out (lb_dq_out),
    .lb_dq_oe  (lb_dq_oe),
    .hp_dq_out (hp_dq_out),
    .hp_dq_oe  (hp_dq_oe)
  );

  bridge_ready u_rdy (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc    (acc_w),
    .hit    (hit_w),
    .hp_rdy (hp_rdy),
    .ready  (lb_ready),
    .done   (done_w)
  );

  assign lb_int = ~hp_int_n;
endmodule

// File: rtl/bridge_chk.sv
`timescale 1ns/1ps
module bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] lb_cs_n,
  input logic       lb_rd_n,
  input logic       lb_dq_oe,
  input logic       hp_dq_oe,
  input logic       hp_cs_n,
  input logic       lb_ready,
  input logic       hp_rdy,
  input logic       acc,
  input logic       hit,
  input logic       done
);
  // R1: ready low during reset
  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r1: assert (!lb_ready);

  p_select_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_cs_n |-> !(lb_cs_n[0] & lb_cs_n[1]));

  p_lb_oe_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lb_dq_oe |-> (!lb_rd_n && !(lb_cs_n[0] & lb_cs_n[1])));

  p_no_pad_fight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_dq_oe && hp_dq_oe));

  p_ready_waits_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit && !hp_rdy) |=> !lb_ready);

  p_ready_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lb_ready |=> !lb_ready);

  p_ready_from_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lb_ready) |-> $past(acc));

  p_miss_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hit && !done && !lb_ready) |=> lb_ready);
endmodule

bind lbus_hp_bridge bridge_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lb_cs_n  (lb_cs_n),
  .lb_rd_n  (lb_rd_n),
  .lb_dq_oe (lb_dq_oe),
  .hp_dq_oe (hp_dq_oe),
  .hp_cs_n  (hp_cs_n),
  .lb_ready (lb_ready),
  .hp_rdy   (hp_rdy),
  .acc      (acc_w),
  .hit      (hit_w),
  .done     (done_w)
);

// File: tb/lbus_hp_bridge_test.sv
`timescale 1ns/1ps
module lbus_hp_bridge_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lb_cs_n = 2'b11;
  logic [1:0] lb_addr_hi = 2'b00;
  logic       lb_be0 = 1'b0;
  logic       lb_wnr = 1'b0;
  logic       lb_rd_n = 1'b1;
  logic       lb_wr_n = 1'b1;
  logic [7:0] lb_dq_in = 8'h00;
  logic [7:0] lb_dq_out;
  logic       lb_dq_oe, lb_ready, lb_int;
  logic       hp_cs_n, hp_byte_sel, hp_rnw, hp_ds1_n, hp_ds2_n, hp_dq_oe;
  logic [1:0] hp_rsel;
  logic [7:0] hp_dq_in = 8'h00;
  logic [7:0] hp_dq_out;
  logic       hp_rdy = 1'b0;
  logic       hp_int_n = 1'b1;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lbus_hp_bridge uut (.*);

  typedef struct {
    string       req;
    logic [26:0] exp;
  } item_t;

  item_t sb[$];
  event  pushed;

  function automatic logic [26:0] actual_vec();
    return {hp_cs_n, hp_rsel, hp_byte_sel, hp_rnw, hp_ds1_n, hp_ds2_n,
            lb_int, lb_dq_oe, lb_dq_out, hp_dq_oe, hp_dq_out, lb_ready};
  endfunction

  // Expected outputs from the requirement text, for the present inputs.
  function automatic logic [26:0] model_vec(logic rdy);
    logic       reg_win, str_win, win, sel;
    logic [1:0] code;
    reg_win = !lb_cs_n[0] && (lb_addr_hi != 2'b01);
    str_win = lb_cs_n[0] && !lb_cs_n[1];
    win     = reg_win || str_win;
    sel     = (lb_cs_n != 2'b11);
    code    = !lb_cs_n[0] ? lb_addr_hi : 2'b01;
    return {!win, code, lb_be0, !lb_wnr, lb_rd_n, lb_wr_n,
            !hp_int_n, sel && !lb_rd_n, (win ? hp_dq_in : 8'hFF),
            win && !lb_wr_n && lb_wnr, lb_dq_in, rdy};
  endfunction

  task automatic expect_now(string req, logic rdy);
    item_t it;
    it.req = req;
    it.exp = model_vec(rdy);
    sb.push_back(it);
    ->pushed;
    #1;
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic set_bus(logic [1:0] cs, logic [1:0] a, logic be, logic wnr,
                         logic rd, logic wr, logic [7:0] d);
    lb_cs_n = cs; lb_addr_hi = a; lb_be0 = be; lb_wnr = wnr;
    lb_rd_n = rd; lb_wr_n = wr; lb_dq_in = d;
  endtask

  task automatic idle();
    set_bus(2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, lb_dq_in);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(pushed);
      while (sb.size() > 0) begin
        item_t it;
        logic [26:0] act;
        it  = sb.pop_front();
        act = actual_vec();
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cycle(); cycle();
    expect_now("R1 ready low in reset", 1'b0);
    rst_n = 1'b1;
    cycle();
    expect_now("R1 idle after reset", 1'b0);

    // R2 R3 R5 R7: register window reads of each code, data from host pad
    foreach (lb_addr_hi[i]) ; // no-op keeps loop style consistent
    for (int k = 0; k < 4; k++) begin
      if (k == 1) continue;
      hp_dq_in = 8'h30 + 8'(k);
      hp_rdy = 1'b1;
      set_bus(2'b10, 2'(k), 1'(k), 1'b0, 1'b0, 1'b1, 8'h00);
      expect_now("R3 register window read code", 1'b0);
      cycle();
      expect_now("R9 ready after host ready", 1'b1);
      cycle();
      expect_now("R10 ready drops", 1'b0);
      idle();
      hp_rdy = 1'b0;
      expect_now("R5 strobes idle", 1'b0);
      cycle();
    end

    // R3: streaming window forces auto-increment code
    hp_dq_in = 8'hA5;
    hp_rdy = 1'b1;
    set_bus(2'b01, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    expect_now("R3 streaming window code 01", 1'b0);
    cycle();
    expect_now("R9 streaming ready", 1'b1);
    idle(); hp_rdy = 1'b0;
    cycle();

    // R2: both chip selects low, register window wins
    set_bus(2'b00, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11);
    expect_now("R2 cs0 priority no strobe", 1'b0);
    // R4 R8: write through register window, byte select high
    hp_rdy = 1'b1;
    set_bus(2'b10, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 8'h5C);
    expect_now("R8 write data to host pad", 1'b0);
    cycle();
    expect_now("R4 write ready", 1'b1);
    idle(); hp_rdy = 1'b0;
    cycle();
    // R4 R8: write with direction low does not drive host pad
    set_bus(2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3);
    expect_now("R4 direction low no strobe", 1'b0);
    idle();

    // R6: interrupt inversion
    hp_int_n = 1'b0;
    expect_now("R6 interrupt asserted", 1'b0);
    hp_int_n = 1'b1;
    expect_now("R6 interrupt released", 1'b0);

    // R9 R10: host ready held low, then held strobe after pulse
    hp_dq_in = 8'h77;
    set_bus(2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    expect_now("R9 wait start", 1'b0);
    for (int w = 0; w < 3; w++) begin
      cycle();
      expect_now("R9 waiting on host ready", 1'b0);
    end
    hp_rdy = 1'b1;
    expect_now("R9 host ready before edge", 1'b0);
    cycle();
    expect_now("R9 ready rises", 1'b1);
    for (int w = 0; w < 3; w++) begin
      cycle();
      expect_now("R10 single pulse while strobe held", 1'b0);
    end
    idle();
    cycle();
    expect_now("R10 released", 1'b0);
    // R10: rearmed on a new byte
    set_bus(2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    cycle();
    expect_now("R10 rearmed next byte", 1'b1);
    idle(); hp_rdy = 1'b0;
    cycle();

    // R11 R7: register window with streaming code misses, 8'hFF returned
    set_bus(2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    expect_now("R7 missed read returns FF", 1'b0);
    cycle();
    expect_now("R11 miss ready without host ready", 1'b1);
    cycle();
    expect_now("R11 miss single pulse", 1'b0);
    idle();
    cycle();
    expect_now("R1 idle quiet", 1'b0);

    finished = 1;
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule